// File: doc/BRIEF.md
# Password-Unlocked Block Lock Register

This block is a 32-bit memory-mapped register that guards storage blocks against program and erase. It holds one lock bit per block, split into three groups (low, mid and upper). A sticky unlock flag, readable but never directly writable, decides whether software may change those lock bits. The flag starts cleared after reset. The only way to set it is to write one fixed 32-bit key word to the register. Once set, the flag stays set until the next reset.

At reset, each lock bit takes its value from a non-volatile configuration word that arrives on an input port. An erased configuration reads as all ones, so an erased configuration comes up with every block locked. The block ORs its own lock bits with a second, independent lock vector. The result drives a per-block `locked` output, and the program/erase request path samples that output to refuse work on protected blocks.

The register is reached through a plain single-cycle 32-bit bus. A write is captured on the clock edge where `bus_we_i` is high. A read is combinational on the address. This bus has no data stream, so it has no valid/ready handshake and never applies back-pressure. Every access completes in the cycle it is presented.

Top module: `blk_lock_reg`

## Requirements
- R1: During and right after a synchronous reset (`rst_ni` low at a clock edge), the unlock flag (read-back bit 31) is 0 and each lock bit equals the matching bit of `nvm_cfg_i`.
- R2: An erased configuration word (all ones on `nvm_cfg_i`) resets every lock bit to 1.
- R3: A write of exactly 0xA1A1_1111 at offset 0x04 sets the unlock flag from the next cycle onward. A write of any other value leaves the flag unchanged.
- R4: Once set, the unlock flag stays set until reset. No write, including one with bit 31 clear, clears it.
- R5: While the unlock flag is 0, writes to offset 0x04 leave all lock bits unchanged.
- R6: While the unlock flag is 1, a non-key write at offset 0x04 loads the lock bits from the write data on the next cycle. Field positions: low group bits [9:0], mid group bits [17:16], upper group bits [21:20].
- R7: A key write never changes the lock bits in its own cycle, even when the flag is already set.
- R8: `locked_o` equals the stored lock bits ORed bit by bit with `sec_lock_i`, in vector order {upper[1:0], mid[1:0], low[9:0]}. It follows `sec_lock_i` combinationally.
- R9: Read-back at offset 0x04 returns the lock fields at the positions of R6 and the flag at bit 31, with all other bits 0. Reads at any other address return 0. Writes at any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| nvm_cfg_i | input | 14 | Reset values for the lock bits, taken from non-volatile configuration |
| bus_addr_i | input | 8 | Register byte address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| sec_lock_i | input | 14 | Secondary lock vector, ORed into the result |
| locked_o | output | 14 | Effective per-block lock status |

## Verification
Assertions check on every cycle that the unlock flag is sticky and is set by a key write. They also check that lock bits hold while locked out or on a key write, that read-back keeps reserved bits and foreign addresses at zero, and that with no secondary lock the output equals the stored locks. Only the bench scenarios can show the rest: the exact reset values loaded from configuration (including the erased case), that a near-miss key does not unlock, and that enabled writes place each field at the stated bit positions. The bench mixes random writes, keys, foreign addresses, secondary-lock changes and resets against a reference model.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hA1A1_1111;
  localparam int unsigned FLAG_BIT = 31;
  localparam int unsigned NGRP     = 3;
endpackage

// File: rtl/blk_lock_key_det.sv
module blk_lock_key_det
  import blk_lock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              key_hit_o,
  output logic              unlock_o
);
  logic unlock_q;

  assign key_hit_o = wr_hit_i && (wdata_i == UNLOCK_KEY);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        unlock_q <= 1'b0;
    else if (key_hit_o) unlock_q <= 1'b1;
  end

  assign unlock_o = unlock_q;

  // R1
  reset_clears_flag_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !unlock_q);

  // R3
  key_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_hit_o |=> unlock_q);

  // R4
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_q |=> unlock_q);
endmodule

// File: rtl/blk_lock_group.sv
module blk_lock_group
  import blk_lock_pkg::*;
#(
  parameter int unsigned N    = 2,
  parameter int unsigned BASE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      cfg_i,
  input  logic              wr_hit_i,
  input  logic              unlock_i,
  input  logic              key_hit_i,
  input  logic [N-1:0]      wfield_i,
  output logic [N-1:0]      lock_o,
  output logic [DATA_W-1:0] rd_word_o
);
  logic [N-1:0] lock_q;
  logic         upd;

  assign upd = wr_hit_i && unlock_i && !key_hit_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)  lock_q <= cfg_i;
    else if (upd) lock_q <= wfield_i;
  end

  assign lock_o = lock_q;

  always_comb begin
    rd_word_o = '0;
    rd_word_o[BASE +: N] = lock_q;
  end

  // R5
  locked_out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_i |=> $stable(lock_q));

  // R7
  key_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_hit_i |=> $stable(lock_q));
endmodule

// File: rtl/blk_lock_merge.sv
module blk_lock_merge #(
  parameter int unsigned N = 14
) (
  input  logic [N-1:0] own_i,
  input  logic [N-1:0] sec_i,
  output logic [N-1:0] locked_o
);
  assign locked_o = own_i | sec_i;
endmodule

// File: rtl/blk_lock_reg.sv
module blk_lock_reg
  import blk_lock_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  REG_OFS  = 8'h04,
  parameter int unsigned LOW_N    = 10,
  parameter int unsigned MID_N    = 2,
  parameter int unsigned UP_N     = 2,
  parameter int unsigned LOW_BASE = 0,
  parameter int unsigned MID_BASE = 16,
  parameter int unsigned UP_BASE  = 20,
  localparam int unsigned TOTAL_N = LOW_N + MID_N + UP_N
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TOTAL_N-1:0] nvm_cfg_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [TOTAL_N-1:0] sec_lock_i,
  output logic [TOTAL_N-1:0] locked_o
);
  localparam int unsigned GW [NGRP] = '{LOW_N, MID_N, UP_N};
  localparam int unsigned GB [NGRP] = '{LOW_BASE, MID_BASE, UP_BASE};
  localparam int unsigned GO [NGRP] = '{0, LOW_N, LOW_N + MID_N};
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

  logic               addr_hit, wr_hit, key_hit, unlock;
  logic [TOTAL_N-1:0] lock_all;
  logic [DATA_W-1:0]  grp_rd [NGRP];
  logic [DATA_W-1:0]  rd_word;

  assign addr_hit = (bus_addr_i == OFS);
  assign wr_hit   = addr_hit && bus_we_i;

  blk_lock_key_det u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_hit_i  (wr_hit),
    .wdata_i   (bus_wdata_i),
    .key_hit_o (key_hit),
    .unlock_o  (unlock)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    blk_lock_group #(.N(GW[g]), .BASE(GB[g])) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_i     (nvm_cfg_i[GO[g] +: GW[g]]),
      .wr_hit_i  (wr_hit),
      .unlock_i  (unlock),
      .key_hit_i (key_hit),
      .wfield_i  (bus_wdata_i[GB[g] +: GW[g]]),
      .lock_o    (lock_all[GO[g] +: GW[g]]),
      .rd_word_o (grp_rd[g])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int g = 0; g < NGRP; g++) rd_word = rd_word | grp_rd[g];
    rd_word[FLAG_BIT] = unlock;
  end

  assign bus_rdata_o = addr_hit ? rd_word : '0;

  blk_lock_merge #(.N(TOTAL_N)) u_merge (
    .own_i    (lock_all),
    .sec_i    (sec_lock_i),
    .locked_o (locked_o)
  );

  localparam logic [DATA_W-1:0] USED_MASK =
      (DATA_W'((1 << LOW_N) - 1) << LOW_BASE) |
      (DATA_W'((1 << MID_N) - 1) << MID_BASE) |
      (DATA_W'((1 << UP_N) - 1) << UP_BASE) |
      (DATA_W'(1) << FLAG_BIT);

  // R9
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rdata_o & ~USED_MASK) == '0);

  // R9
  foreign_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_hit |-> bus_rdata_o == '0);

  // R8
  no_sec_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_lock_i == '0) |-> (locked_o == lock_all));
endmodule

// File: tb/blk_lock_reg_tb_top.sv
module blk_lock_reg_tb_top;
  localparam int N = 14;
  localparam logic [31:0] KEY = 32'hA1A1_1111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] cfg = '1;
  logic [7:0]  addr = 8'h04;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] sec = '0;
  logic [N-1:0] locked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0] m_lock;
  bit           m_en;

  always #2 clk = ~clk;

  blk_lock_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .nvm_cfg_i(cfg),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .sec_lock_i(sec), .locked_o(locked)
  );

  function automatic logic [N-1:0] fields_of(input logic [31:0] d);
    return {d[21:20], d[17:16], d[9:0]};
  endfunction

  function automatic logic [31:0] word_of(input logic [N-1:0] l, input bit en);
    logic [31:0] w = '0;
    w[9:0]   = l[9:0];
    w[17:16] = l[11:10];
    w[21:20] = l[13:12];
    w[31]    = en;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    addr = 8'h04;
    #1;
    chk({req, " rdata"}, rdata, word_of(m_lock, m_en));
    chk({req, " locked"}, 32'(locked), 32'(m_lock | sec));
  endtask

  task automatic do_reset(input logic [N-1:0] c);
    @(negedge clk);
    rst_n = 1'b0; cfg = c; we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_lock = c; m_en = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 8'h04;
    if (a == 8'h04) begin
      if (d == KEY) m_en = 1;
      else if (m_en) m_lock = fields_of(d);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    // R1: reset state from configuration
    do_reset(14'h2A5C);
    check_all("R1 reset");
    // R2: erased configuration
    do_reset('1);
    check_all("R2 erased");
    // R5: write while locked out
    wr(8'h04, 32'h0000_0000);
    check_all("R5 locked-out write");
    // R3: near-miss key
    wr(8'h04, 32'hA1A1_1110);
    check_all("R3 near-miss key");
    // R3: key write
    wr(8'h04, KEY);
    check_all("R3 key");
    // R6: field placement
    wr(8'h04, 32'h0022_0155);
    check_all("R6 enabled write");
    // R7: key while enabled leaves locks
    wr(8'h04, KEY);
    check_all("R7 key no update");
    // R4: bit31 clear does not clear flag
    wr(8'h04, 32'h0000_0000);
    check_all("R4 sticky");
    // R9: foreign address write and read
    wr(8'h08, 32'hFFFF_FFFF);
    check_all("R9 foreign write");
    addr = 8'h08; #1;
    chk("R9 foreign read", rdata, 32'h0);
    // R8: secondary lock merge
    @(negedge clk); sec = 14'h1001;
    check_all("R8 merge");
    // R1: reset clears the flag again
    do_reset(14'h0000);
    check_all("R1 reset after unlock");

    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: wr(8'h04, KEY);
        1: wr(8'($urandom_range(0, 15) * 4), $urandom);
        2: begin @(negedge clk); sec = N'($urandom); end
        3: if ($urandom_range(0, 9) == 0) do_reset(N'($urandom));
        default: wr(8'h04, $urandom);
      endcase
      check_all("R6 random");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule